// File: doc/BRIEF.md
# Hybrid Static/Dynamic Branch Direction Predictor

This block guesses the direction of conditional branches for an instruction fetch unit. Each fetch-side lookup carries the branch address, the sign of its displacement and a mode flag that the instruction translation supplies for the page holding the branch. When the flag selects the static rule, only the displacement sign matters. Backward branches are guessed taken and forward branches are guessed not taken. When the flag selects the dynamic scheme, the guess comes from a table of short outcome histories. The table is addressed by low bits of the branch address.

Each history entry holds the last three resolved outcomes of whatever branches map to it. An entry predicts taken when most of those outcomes were taken. The resolve side writes the real outcome of every branch back into its entry, no matter which scheme the fetch used. This keeps every history current in case a page later changes mode.

The lookup path is a valid/ready stream that ends in a single registered prediction slot. A lookup is accepted when `lk_valid` and `lk_ready` are both high at a clock edge. Its prediction appears on `pr_taken` with `pr_valid` high after that edge. The result stays there unchanged until the consumer raises `pr_ready`. While the slot is full and `pr_ready` is low, `lk_ready` is low and no new lookup is taken in. When `pr_ready` is high, one lookup can be accepted on every cycle. The resolve side is a plain strobe that is always accepted.

Top module: `bp_hybrid_predictor`

## Requirements
- R1: After reset, `pr_valid` is 0, `lk_ready` is 1, and every history entry is 3'b000, so every dynamic-mode lookup predicts not taken.
- R2: With `lk_use_dyn` = 0 (static mode), the prediction equals `lk_disp_neg`: 1 (backward branch) gives taken, 0 gives not taken. The history contents have no effect.
- R3: With `lk_use_dyn` = 1 (dynamic mode), the prediction is taken exactly when two or more of the three bits in the indexed history entry are 1.
- R4: When `rs_valid` is high at an edge, the indexed entry shifts left by one. `rs_taken` enters at bit 0 and the oldest outcome (bit 2) is discarded.
- R5: A resolve updates the history whatever mode was used at fetch time. A later static lookup of that branch is unchanged by the update, while a later dynamic lookup reflects it.
- R6: Both sides index the table with PC bits [IDX_W+1:2] and keep no tag. Addresses that differ only in bits [1:0] or above bit IDX_W+1 share one entry.
- R7: When a lookup and a resolve hit the same entry at the same edge, the lookup sees the entry value from before the update.
- R8: An accepted lookup produces `pr_valid` = 1 with its prediction in the cycle after the accepting edge. If the slot is drained with no new acceptance, `pr_valid` returns to 0 on the next edge.
- R9: While `pr_valid` is 1 and `pr_ready` is 0, `lk_ready` is 0 and `pr_taken` holds its value, whatever is presented on the lookup inputs.
- R10: While `pr_ready` is 1, `lk_ready` is 1, and back-to-back lookups are accepted on consecutive cycles, each producing its own prediction one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | PC_W | Branch address of the lookup |
| lk_disp_neg | input | 1 | 1 when the branch displacement is negative |
| lk_use_dyn | input | 1 | Page mode flag: 1 selects the history table, 0 the static rule |
| rs_valid | input | 1 | Resolve strobe |
| rs_pc | input | PC_W | Branch address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 for taken |
| pr_valid | output | 1 | Prediction slot holds a result |
| pr_ready | input | 1 | Consumer takes the prediction |
| pr_taken | output | 1 | Predicted direction, 1 for taken |

## Verification
The bench builds the block with PC_W = 32, IDX_W = 4 and HIST_W = 3. This gives a 16-entry table, so the reset state of every entry can be swept by lookup in a few dozen cycles. The shallow index also makes aliasing easy to provoke: addresses that differ only in bit 12, bit 31 or the byte offset land on the same entry. The three-bit history length is kept, so the full shift-and-vote sequence and the same-cycle read-before-write case are exercised at the default width.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Source of a direction guess, as chosen by the per-page flag.
  typedef enum logic {
    MODE_STATIC  = 1'b0,
    MODE_DYNAMIC = 1'b1
  } bp_mode_e;

  // Word-aligned fetch: the two lowest address bits never index the table.
  localparam int unsigned BP_IDX_LSB = 2;

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist
);

  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned FLAT_W = DEPTH * HIST_W;

  logic [FLAT_W-1:0] flat_q;

  // One shift register per entry; only the addressed one moves.
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [HIST_W-1:0] hist_q;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_q <= '0;
      end else if (hit) begin
        hist_q <= {hist_q[HIST_W-2:0], wr_bit};
      end
    end

    assign flat_q[e*HIST_W +: HIST_W] = hist_q;
  end

  // Read port sees register outputs: a same-edge write is not forwarded.
  assign rd_hist = flat_q[rd_idx*HIST_W +: HIST_W];

endmodule

// File: rtl/bp_vote.sv
module bp_vote #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] hist,
  output logic         taken
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] HALF = CW'(W / 2);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(hist[i]);
    end
  end

  // Strict majority of recorded outcomes.
  assign taken = (ones > HALF);

endmodule

// File: rtl/bp_out_stage.sv
module bp_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_taken,
  output logic out_valid,
  input  logic out_ready,
  output logic out_taken
);

  logic valid_q;
  logic taken_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      valid_q <= 1'b1;
      taken_q <= in_taken;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_taken = taken_q;

endmodule

// File: rtl/bp_hybrid_predictor.sv
module bp_hybrid_predictor #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_disp_neg,
  input  logic            lk_use_dyn,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  output logic            pr_valid,
  input  logic            pr_ready,
  output logic            pr_taken
);

  import bp_pkg::*;

  localparam int unsigned LSB    = BP_IDX_LSB;
  localparam int unsigned IDX_HI = LSB + IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  rs_idx;
  logic [HIST_W-1:0] lk_hist;
  logic              dyn_guess;
  logic              static_guess;
  logic              guess;
  bp_mode_e          lk_mode;

  assign lk_idx = lk_pc[LSB +: IDX_W];
  assign rs_idx = rs_pc[LSB +: IDX_W];

  // Address bits outside the index take no part (no tag kept).
  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI], lk_pc[LSB-1:0],
                            rs_pc[PC_W-1:IDX_HI], rs_pc[LSB-1:0]};

  bp_hist_table #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rs_valid),
    .wr_idx  (rs_idx),
    .wr_bit  (rs_taken),
    .rd_idx  (lk_idx),
    .rd_hist (lk_hist)
  );

  bp_vote #(
    .W (HIST_W)
  ) u_vote (
    .hist  (lk_hist),
    .taken (dyn_guess)
  );

  // Backward displacement is guessed taken, forward not taken.
  assign static_guess = lk_disp_neg;
  assign lk_mode      = bp_mode_e'(lk_use_dyn);
  assign guess        = (lk_mode == MODE_DYNAMIC) ? dyn_guess : static_guess;

  bp_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lk_valid),
    .in_ready  (lk_ready),
    .in_taken  (guess),
    .out_valid (pr_valid),
    .out_ready (pr_ready),
    .out_taken (pr_taken)
  );

endmodule

// File: rtl/bp_hybrid_checker.sv
module bp_hybrid_checker (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_ready,
  input logic lk_disp_neg,
  input logic lk_use_dyn,
  input logic pr_valid,
  input logic pr_ready,
  input logic pr_taken
);

  // R9: a stalled result stays put.
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_taken));

  // R9: a full, unread slot refuses new lookups.
  p_stall_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |-> !lk_ready);

  // R8: an accepted lookup yields a result on the next cycle.
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> pr_valid);

  // R8: a drained slot with no new acceptance empties.
  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && pr_ready && !(lk_valid && lk_ready) |=> !pr_valid);

  // R2: static mode follows the displacement sign.
  p_static_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && !lk_use_dyn |=> pr_taken == $past(lk_disp_neg));

  // R10: an empty slot always accepts.
  p_empty_accepts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_valid |-> lk_ready);

endmodule

bind bp_hybrid_predictor bp_hybrid_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_ready    (lk_ready),
  .lk_disp_neg (lk_disp_neg),
  .lk_use_dyn  (lk_use_dyn),
  .pr_valid    (pr_valid),
  .pr_ready    (pr_ready),
  .pr_taken    (pr_taken)
);

// File: tb/sim_bp_hybrid_predictor.sv
module sim_bp_hybrid_predictor;

  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned HW    = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            lk_valid;
  logic            lk_ready;
  logic [PC_W-1:0] lk_pc;
  logic            lk_disp_neg;
  logic            lk_use_dyn;
  logic            rs_valid;
  logic [PC_W-1:0] rs_pc;
  logic            rs_taken;
  logic            pr_valid;
  logic            pr_ready;
  logic            pr_taken;

  int n_cmp = 0;
  int n_bad = 0;

  logic [HW-1:0] mh [16];

  always #10 clk = ~clk;

  bp_hybrid_predictor #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .HIST_W (HW)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_pc       (lk_pc),
    .lk_disp_neg (lk_disp_neg),
    .lk_use_dyn  (lk_use_dyn),
    .rs_valid    (rs_valid),
    .rs_pc       (rs_pc),
    .rs_taken    (rs_taken),
    .pr_valid    (pr_valid),
    .pr_ready    (pr_ready),
    .pr_taken    (pr_taken)
  );

  function automatic logic maj(input logic [HW-1:0] h);
    return ($countones(h) >= 2);
  endfunction

  function automatic int ix(input logic [PC_W-1:0] pc);
    return int'(pc[5:2]);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // All scenario tasks start and end at a falling edge.
  task automatic lookup(input logic [PC_W-1:0] pc, input logic neg,
                        input logic dyn, input logic exp, input string req);
    lk_valid = 1'b1; lk_pc = pc; lk_disp_neg = neg; lk_use_dyn = dyn;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, pr_valid, 1'b1);
    chk(req, pr_taken, exp);
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic t);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t;
    @(negedge clk);
    rs_valid = 1'b0;
    mh[ix(pc)] = {mh[ix(pc)][HW-2:0], t};
  endtask

  task automatic t_reset;
    chk("R1 pr_valid after reset", pr_valid, 1'b0);
    chk("R1 lk_ready after reset", lk_ready, 1'b1);
    for (int k = 0; k < 16; k++) begin
      lookup(PC_W'(k << 2), 1'b0, 1'b1, 1'b0, "R1 cleared entry");
    end
    @(negedge clk);
    chk("R8 slot empties when drained", pr_valid, 1'b0);
  endtask

  task automatic t_static;
    resolve(32'h0000_000C, 1'b1);
    resolve(32'h0000_000C, 1'b1);
    resolve(32'h0000_000C, 1'b1);
    lookup(32'h0000_000C, 1'b0, 1'b0, 1'b0, "R2 forward, hot entry");
    lookup(32'h0000_000C, 1'b1, 1'b0, 1'b1, "R2 backward, hot entry");
    lookup(32'h0000_0010, 1'b1, 1'b0, 1'b1, "R2 backward, cold entry");
    lookup(32'h0000_0010, 1'b0, 1'b0, 1'b0, "R2 forward, cold entry");
    lookup(32'h0000_000C, 1'b0, 1'b1, 1'b1, "R3 all-taken entry");
  endtask

  task automatic t_shift;
    logic seq [7] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 7; i++) begin
      resolve(32'h0000_001C, seq[i]);
      lookup(32'h0000_001C, 1'b0, 1'b1, maj(mh[7]), "R4 R3 shift and vote");
    end
    // After T,T,N,N,T,N,T the entry holds 3'b101: taken.
    chk("R4 final history vote", pr_taken, 1'b1);
  endtask

  task automatic t_alias;
    resolve(32'h0000_1027, 1'b1);
    resolve(32'h0000_1027, 1'b1);
    lookup(32'h0000_0024, 1'b0, 1'b1, 1'b1, "R6 alias via high and low bits");
    lookup(32'h8000_0024, 1'b1, 1'b1, 1'b1, "R6 alias via bit 31");
    lookup(32'h0000_0028, 1'b1, 1'b1, 1'b0, "R6 neighbour untouched");
  endtask

  task automatic t_mode_free_update;
    resolve(32'h0000_002C, 1'b1);
    lookup(32'h0000_002C, 1'b0, 1'b0, 1'b0, "R5 static ignores history");
    resolve(32'h0000_002C, 1'b1);
    lookup(32'h0000_002C, 1'b0, 1'b0, 1'b0, "R5 static ignores history");
    lookup(32'h0000_002C, 1'b0, 1'b1, 1'b1, "R5 dynamic sees updates");
  endtask

  task automatic t_collide;
    resolve(32'h0000_0030, 1'b1);
    rs_valid = 1'b1; rs_pc = 32'h0000_0030; rs_taken = 1'b1;
    lookup(32'h0000_0030, 1'b0, 1'b1, 1'b0, "R7 same-edge sees old value");
    rs_valid = 1'b0;
    mh[12] = {mh[12][HW-2:0], 1'b1};
    lookup(32'h0000_0030, 1'b0, 1'b1, 1'b1, "R7 next lookup sees update");
  endtask

  task automatic t_backpressure;
    pr_ready = 1'b0;
    lookup(32'h0000_000C, 1'b0, 1'b1, 1'b1, "R9 stalled result");
    lk_valid = 1'b1; lk_pc = 32'h0000_000C; lk_disp_neg = 1'b0; lk_use_dyn = 1'b0;
    for (int c = 0; c < 2; c++) begin
      chk("R9 lk_ready low while stalled", lk_ready, 1'b0);
      @(negedge clk);
      chk("R9 pr_valid held", pr_valid, 1'b1);
      chk("R9 pr_taken held", pr_taken, 1'b1);
    end
    pr_ready = 1'b1;
    #1;
    chk("R10 lk_ready with pr_ready", lk_ready, 1'b1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 waiting lookup taken on release", pr_valid, 1'b1);
    chk("R9 waiting lookup result", pr_taken, 1'b0);
    @(negedge clk);
    chk("R8 slot empties after release", pr_valid, 1'b0);
  endtask

  task automatic t_stream;
    lookup(32'h0000_0100, 1'b1, 1'b0, 1'b1, "R10 stream 0");
    chk("R10 ready in stream", lk_ready, 1'b1);
    lookup(32'h0000_0104, 1'b0, 1'b0, 1'b0, "R10 stream 1");
    chk("R10 ready in stream", lk_ready, 1'b1);
    lookup(32'h0000_000C, 1'b0, 1'b1, 1'b1, "R10 stream 2");
    lookup(32'h0000_0010, 1'b1, 1'b1, 1'b0, "R10 stream 3");
    lookup(32'h0000_0108, 1'b1, 1'b0, 1'b1, "R10 stream 4");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) mh[k] = '0;
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0; lk_disp_neg = 1'b0;
    lk_use_dyn = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0;
    pr_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_static();
    t_shift();
    t_alias();
    t_mode_free_update();
    t_collide();
    t_backpressure();
    t_stream();
    @(negedge clk);
    summary();
    $finish;
  end

endmodule